// File: doc/BRIEF.md
# Single-Bus Accumulate Datapath

This block is a small processor datapath in which every register transfer travels over one shared internal bus. The instruction address field, the memory buffer, the accumulator and the ALU result register can each be gated onto that bus. The memory address register, the Y temporary, the Z result register and the accumulator can each be loaded from it. The ALU keeps no state of its own. One operand is taken straight off the bus and the other from Y, and its result, carry and zero indication are caught in Z.

A step sequencer produces the gate controls. A `start` pulse captures an operand address and an operation select, then walks five states in order: ST_ADDR (instruction address field to MAR), ST_FETCH (memory read into MBR), ST_STAGE (MBR to Y), ST_SUM (AC on the bus, ALU result into Z) and ST_WB (Z to AC). The sequencer then returns to ST_IDLE.

The transitions are:
- ST_IDLE to ST_ADDR on an accepted start.
- Each step to the next on every clock.
- ST_WB back to ST_IDLE.

The operation is either an add (AC plus memory) or a pass (AC takes the memory word).

Top module: `sbus_acc_path`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `mem_rd`, `acc`, `carry` and `zero` are all 0 until a start is accepted.
- R2: A `start` sampled high while idle latches `ld_addr` and `op_sel`. `busy` is then high for exactly five cycles. `mem_rd` is high only in the second of those cycles, with `mem_addr` equal to the latched address, and `mem_rdata` is taken in that cycle.
- R3: With `op_sel` = 0 (add), `acc` becomes the old `acc` plus the memory word, modulo 2^DATA_W. `done` is high for exactly one cycle, the cycle right after the fifth busy cycle, and the new `acc` is visible in that cycle.
- R4: `carry` is the carry-out of that addition and `zero` is 1 exactly when the new `acc` is 0. Both change in the same cycle as `acc`.
- R5: With `op_sel` = 1 (pass), `acc` becomes the memory word, `carry` becomes 0, and `zero` reflects that word.
- R6: A `start` while busy is ignored. The running sequence keeps its length, address, operation and result.
- R7: No more than one source drives the internal bus in any cycle.
- R8: The ALU operand held in Y equals the fetched memory word during the sum step.
- R9: A `start` in the cycle where `done` is high is accepted, so operations can run back to back with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation when idle |
| op_sel | input | 1 | 0 = add memory to AC, 1 = pass memory to AC |
| ld_addr | input | ADDR_W | Operand address captured at start |
| mem_addr | output | ADDR_W | Memory address (MAR contents) |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, combinational from `mem_addr` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse once AC is updated |
| acc | output | DATA_W | Accumulator |
| carry | output | 1 | Carry-out of the last result |
| zero | output | 1 | Last result was zero |

## Verification
The bench builds the block at DATA_W = 16 and ADDR_W = 8, so it can place the full-scale word 0xFFFF in memory. With that word, a pass followed by an add of 1 wraps the accumulator to zero, which drives the carry and zero flags together. The 8-bit address space is small enough for the bench to fill every location with a computed pattern. This lets a behavioural model predict each fetch, and lets start pulses held across busy cycles and starts issued in the done cycle be compared with that model every clock.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FETCH,
        ST_STAGE,
        ST_SUM,
        ST_WB
    } step_e;

    typedef enum logic {
        OP_ADD  = 1'b0,
        OP_PASS = 1'b1
    } aluop_e;

    typedef struct packed {
        logic drv_ir;
        logic drv_mbr;
        logic drv_ac;
        logic drv_z;
        logic ld_mar;
        logic ld_mbr;
        logic ld_y;
        logic ld_z;
        logic ld_ac;
        logic rd;
    } gate_t;

    localparam int NUM_SRC = 4;
    localparam int SRC_IR  = 0;
    localparam int SRC_MBR = 1;
    localparam int SRC_AC  = 2;
    localparam int SRC_Z   = 3;

endpackage

// File: rtl/sbus_seq.sv
module sbus_seq
    import sbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    output step_e state,
    output gate_t gates,
    output logic  busy,
    output logic  accept,
    output logic  done
);

    step_e state_q, state_d;

    assign accept = start && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_ADDR : ST_IDLE;
            ST_ADDR:  state_d = ST_FETCH;
            ST_FETCH: state_d = ST_STAGE;
            ST_STAGE: state_d = ST_SUM;
            ST_SUM:   state_d = ST_WB;
            ST_WB:    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (state_q == ST_WB);
        end
    end

    always_comb begin
        gates = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ADDR:  begin gates.drv_ir  = 1'b1; gates.ld_mar = 1'b1; end
            ST_FETCH: begin gates.rd      = 1'b1; gates.ld_mbr = 1'b1; end
            ST_STAGE: begin gates.drv_mbr = 1'b1; gates.ld_y   = 1'b1; end
            ST_SUM:   begin gates.drv_ac  = 1'b1; gates.ld_z   = 1'b1; end
            ST_WB:    begin gates.drv_z   = 1'b1; gates.ld_ac  = 1'b1; end
            default:  ;
        endcase
    end

    assign state = state_q;
    assign busy  = (state_q != ST_IDLE);

    // R6: a running sequence is never cut short by another start
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_WB) |=> (state_q != ST_IDLE && state_q != ST_ADDR));

    // R3: done lasts a single cycle
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the fetch step always follows the address step
    assert_fetch_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gates.ld_mar |=> gates.rd);

endmodule

// File: rtl/sbus_bus.sv
module sbus_bus #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        drv,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);

    logic [N-1:0][W-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = src[i] & {W{drv[i]}};
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | gated[i];
        end
    end

    // R7: at most one source on the bus
    assert_single_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv));

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_bus,
    input  logic [W-1:0] b_tmp,
    input  aluop_e       op,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         is_zero
);

    logic [W:0] wide;

    always_comb begin
        unique case (op)
            OP_ADD:  wide = {1'b0, a_bus} + {1'b0, b_tmp};
            OP_PASS: wide = {1'b0, b_tmp};
            default: wide = '0;
        endcase
    end

    assign res     = wide[W-1:0];
    assign cout    = wide[W];
    assign is_zero = (wide[W-1:0] == '0);

endmodule

// File: rtl/sbus_acc_path.sv
module sbus_acc_path
    import sbus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_sel,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc,
    output logic              carry,
    output logic              zero
);

    localparam int PAD_W = DATA_W - ADDR_W;

    step_e  state;
    gate_t  gates;
    logic   accept;

    logic [ADDR_W-1:0] ir_q;
    aluop_e            op_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q, y_q, z_q, ac_q;
    logic              zc_q, zz_q, cf_q, zf_q;

    logic [NUM_SRC-1:0]             drv;
    logic [NUM_SRC-1:0][DATA_W-1:0] src;
    logic [DATA_W-1:0]              bus;
    logic [DATA_W-1:0]              alu_res;
    logic                           alu_c, alu_z;

    sbus_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .state  (state),
        .gates  (gates),
        .busy   (busy),
        .accept (accept),
        .done   (done)
    );

    assign drv[SRC_IR]  = gates.drv_ir;
    assign drv[SRC_MBR] = gates.drv_mbr;
    assign drv[SRC_AC]  = gates.drv_ac;
    assign drv[SRC_Z]   = gates.drv_z;
    assign src[SRC_IR]  = {{PAD_W{1'b0}}, ir_q};
    assign src[SRC_MBR] = mbr_q;
    assign src[SRC_AC]  = ac_q;
    assign src[SRC_Z]   = z_q;

    sbus_bus #(.W(DATA_W), .N(NUM_SRC)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .drv   (drv),
        .src   (src),
        .bus   (bus)
    );

    sbus_alu #(.W(DATA_W)) u_alu (
        .a_bus   (bus),
        .b_tmp   (y_q),
        .op      (op_q),
        .res     (alu_res),
        .cout    (alu_c),
        .is_zero (alu_z)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
            op_q <= OP_ADD;
        end else if (accept) begin
            ir_q <= ld_addr;
            op_q <= aluop_e'(op_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar_q <= '0;
            mbr_q <= '0;
            y_q   <= '0;
        end else begin
            if (gates.ld_mar) mar_q <= bus[ADDR_W-1:0];
            if (gates.ld_mbr) mbr_q <= mem_rdata;
            if (gates.ld_y)   y_q   <= bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z_q  <= '0;
            zc_q <= 1'b0;
            zz_q <= 1'b0;
        end else if (gates.ld_z) begin
            z_q  <= alu_res;
            zc_q <= alu_c;
            zz_q <= alu_z;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q <= '0;
            cf_q <= 1'b0;
            zf_q <= 1'b0;
        end else if (gates.ld_ac) begin
            ac_q <= bus;
            cf_q <= zc_q;
            zf_q <= zz_q;
        end
    end

    assign mem_addr = mar_q;
    assign mem_rd   = gates.rd;
    assign acc      = ac_q;
    assign carry    = cf_q;
    assign zero     = zf_q;

    // R2: the read goes to the address captured at start
    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr == ir_q));

    // R3: the accumulator seen with done is the Z result
    assert_ac_from_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc == z_q));

    // R5: a pass never reports a carry
    assert_pass_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_PASS) |-> !carry);

    // R8: Y holds the fetched word while the sum is formed
    assert_y_staged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUM) |-> (y_q == mbr_q));

    // R4: zero flag agrees with the accumulator after an update
    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (zero == (acc == '0)));

endmodule

// File: tb/tb_sbus_acc_path.sv
module tb_sbus_acc_path;

    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_sel = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, carry, zero;
    logic [DW-1:0] acc;

    logic [DW-1:0] mem [0:(1<<AW)-1];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    sbus_acc_path #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .ld_addr(ld_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .acc(acc), .carry(carry), .zero(zero)
    );

    // behavioural reference
    int            step_m = 0;
    logic [AW-1:0] addr_m = '0;
    bit            pass_m = 0;
    logic [DW-1:0] data_m = '0;
    logic [DW-1:0] acc_m = '0;
    bit            cf_m = 0, zf_m = 0, done_m = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            step_m <= 0; acc_m <= '0; cf_m <= 0; zf_m <= 0; done_m <= 0;
        end else begin
            done_m <= 0;
            if (step_m == 0) begin
                if (start) begin
                    step_m <= 1; addr_m <= ld_addr; pass_m <= op_sel;
                end
            end else begin
                if (step_m == 2) data_m <= mem[addr_m];
                if (step_m == 5) begin
                    int sum;
                    if (pass_m) begin
                        sum = int'(data_m);
                    end else begin
                        sum = int'(acc_m) + int'(data_m);
                    end
                    acc_m  <= sum[DW-1:0];
                    cf_m   <= sum[DW];
                    zf_m   <= (sum[DW-1:0] == 0);
                    done_m <= 1;
                    step_m <= 0;
                end else begin
                    step_m <= step_m + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == (step_m != 0), "R2 busy", busy, step_m != 0);
            check(mem_rd == (step_m == 2), "R2 mem_rd", mem_rd, step_m == 2);
            if (step_m == 2)
                check(mem_addr == addr_m, "R2 mem_addr", mem_addr, addr_m);
            check(done == done_m, "R3 done", done, done_m);
            check(acc == acc_m, "R3 acc", acc, acc_m);
            check(carry == cf_m, "R4 carry", carry, cf_m);
            check(zero == zf_m, "R4 zero", zero, zf_m);
        end
    end

    task automatic launch(input logic [AW-1:0] a, input bit p);
        @(negedge clk);
        start = 1'b1; ld_addr = a; op_sel = p;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 16'h0123 + 7);
        mem[0]   = 16'h0000;
        mem[200] = 16'hFFFF;
        mem[201] = 16'h0001;

        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy == 0 && done == 0 && mem_rd == 0, "R1 ctrl in reset", {busy, done, mem_rd}, 0);
        check(acc == 0 && carry == 0 && zero == 0, "R1 data in reset", {acc, carry, zero}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(acc == 0 && !busy, "R1 after release", acc, 0);

        // R3: plain adds
        launch(8'd5, 1'b0);  wait_done();
        check(acc == mem[5], "R3 first add", acc, mem[5]);
        launch(8'd9, 1'b0);  wait_done();
        check(acc == DW'(mem[5] + mem[9]), "R3 second add", acc, DW'(mem[5] + mem[9]));

        // R5: pass loads full-scale word
        launch(8'd200, 1'b1); wait_done();
        check(acc == 16'hFFFF && !carry && !zero, "R5 pass", {acc, carry, zero}, {16'hFFFF, 2'b00});

        // R4: wrap to zero sets carry and zero
        launch(8'd201, 1'b0); wait_done();
        check(acc == 0 && carry && zero, "R4 wrap", {acc, carry, zero}, {16'h0, 2'b11});

        // R5: pass of zero word
        launch(8'd0, 1'b1); wait_done();
        check(acc == 0 && !carry && zero, "R5 pass zero", {acc, carry, zero}, {16'h0, 2'b01});

        // R6: start held high through the whole sequence with other address/op
        @(negedge clk);
        start = 1'b1; ld_addr = 8'd17; op_sel = 1'b1;
        @(negedge clk);
        ld_addr = 8'd33; op_sel = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_done();
        check(acc == mem[17], "R6 ignored restart", acc, mem[17]);

        // R9: back-to-back start in the done cycle
        launch(8'd40, 1'b1); wait_done();
        start = 1'b1; ld_addr = 8'd41; op_sel = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1, "R9 accepted in done cycle", busy, 1);
        wait_done();
        check(acc == DW'(mem[40] + mem[41]), "R9 chained result", acc, DW'(mem[40] + mem[41]));

        // mixed stream
        for (int k = 0; k < 40; k++) begin
            launch(AW'(k * 37 + 3), k[1] & k[0]);
            wait_done();
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule